// File: doc/BRIEF.md
# Reloading Terminal-Count Strobe Counter

This block is a 16-bit unsigned up-counter that produces a periodic one-clock strobe. Every clock cycle where the enable input is high, the count advances by one. Once an enabled count reaches or passes a programmable terminal value, the strobe is raised on the next edge. The edge after that reloads the count to one and clears the strobe, and the cycle starts again.

Two choices shorten the path into the count register. First, the enable is fed in as the carry input of a ripple increment chain, so no hold multiplexer sits in front of the register. Second, the terminal value is captured in a register on every clock before the comparison uses it. Typical uses are tick generators and divided timing pulses, where the terminal value sets the period.

Top module: `stb_reload_counter`

## Requirements
- R1: A rising clock edge with `rst_n` low sets the count to 1 and the strobe to 0.
- R2: On an edge where `en` is high and the strobe is low, the count becomes the previous count plus one, modulo 2^16, so 0xFFFF is followed by 0x0000.
- R3: On an edge where `en` is low and the strobe is low, the count keeps its value and the strobe stays low, even if the count has already reached the terminal value.
- R4: The strobe goes high on an edge if and only if, in the cycle before that edge, `en` was high, the strobe was low, and the count was greater than or equal to the captured terminal value.
- R5: The strobe lasts exactly one cycle. On the edge after a strobe, the count becomes 1 and the strobe clears, whatever the state of `en`.
- R6: With `en` held high and a terminal value T of 1 or more, the strobe repeats every T+1 cycles, and the count reads T+1 while the strobe is high. With T = 0 the period is 2.
- R7: `term_in` is registered on every edge. The comparison uses the value captured at the previous edge, so a change to `term_in` first affects the strobe one edge later.
- R8: Reset takes priority over counting. An edge with `rst_n` low and `en` high still gives a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Count enable; it is also the carry-in of the increment chain |
| term_in | input | 16 | Terminal value, registered every clock |
| count | output | 16 | Current count |
| strobe | output | 1 | One-cycle pulse on a terminal event |

## Verification
A wrong count value shows up on `count` at the very next edge. It also shifts the following strobe away from its T+1 spacing within one period. A strobe register that sticks or fires early shows up within one cycle, because the count then fails to reload to 1 or reloads before reaching T+1. A terminal register that is missing or stale moves the strobe by exactly one edge after `term_in` changes. The latency test is set up so that this single-edge shift is visible.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int unsigned CNT_W = 16;

  // one bit of a ripple adder: sum output
  function automatic logic f_sum_bit(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // one bit of a ripple adder: carry output
  function automatic logic f_carry_bit(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/stb_incr_chain.sv
module stb_incr_chain
  import stb_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic [W-1:0] a_in,
  input  logic         c_in,
  output logic [W-1:0] sum_out
);
  logic [W-1:0] carry;

  assign carry[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_out[i] = f_sum_bit(a_in[i], 1'b0, carry[i]);
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = f_carry_bit(a_in[i], 1'b0, carry[i]);
    end
  end
endmodule

// File: rtl/stb_ge_chain.sv
module stb_ge_chain
  import stb_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         ge_out
);
  // lhs + ~rhs + 1: the carry out of the top bit is high exactly when lhs >= rhs
  logic [W:0] carry;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign carry[i+1] = f_carry_bit(lhs[i], ~rhs[i], carry[i]);
  end

  assign ge_out = carry[W];
endmodule

// File: rtl/stb_term_reg.sv
module stb_term_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  // captured on every edge, with no reset and no enable
  always_ff @(posedge clk) begin
    q_out <= d_in;
  end
endmodule

// File: rtl/stb_reload_counter.sv
module stb_reload_counter
  import stb_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] term_in,
  output logic [W-1:0] count,
  output logic         strobe
);
  localparam logic [W-1:0] RELOAD_VAL = W'(1);

  logic [W-1:0] count_q;
  logic         strobe_q;
  logic [W-1:0] term_q;
  logic [W-1:0] next_count;
  logic         at_term;
  logic         fire;
  logic         reload;

  stb_term_reg #(.W(W)) u_term (
    .clk   (clk),
    .d_in  (term_in),
    .q_out (term_q)
  );

  stb_incr_chain #(.W(W)) u_incr (
    .a_in    (count_q),
    .c_in    (en),
    .sum_out (next_count)
  );

  stb_ge_chain #(.W(W)) u_cmp (
    .lhs    (count_q),
    .rhs    (term_q),
    .ge_out (at_term)
  );

  assign fire   = en & at_term;
  assign reload = ~rst_n | strobe_q;

  always_ff @(posedge clk) begin
    if (reload) begin
      count_q  <= RELOAD_VAL;
      strobe_q <= 1'b0;
    end else begin
      count_q  <= next_count;
      strobe_q <= fire;
    end
  end

  assign count  = count_q;
  assign strobe = strobe_q;
endmodule

// File: rtl/stb_reload_counter_chk.sv
module stb_reload_counter_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [W-1:0] term_in,
  input logic [W-1:0] count,
  input logic         strobe
);
  logic rst_seen;
  logic prev_rst_low;

  always_ff @(posedge clk) begin
    prev_rst_low <= ~rst_n;
    rst_seen     <= 1'b1;
  end

  // R1 / R8: the cycle after a reset edge shows count 1 and strobe 0
  always_ff @(posedge clk) begin
    if (rst_seen && prev_rst_low) begin
      p_reset_load_r1: assert (count == W'(1) && !strobe)
        else $error("p_reset_load_r1");
    end
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !strobe) |=> count == W'($past(count) + W'(1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !strobe) |=> ($stable(count) && !strobe));

  p_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !strobe && count >= $past(term_in)) |=> strobe);

  p_nofire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !(en && count >= $past(term_in))) |=> !strobe);

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (count == W'(1) && !strobe));
endmodule

bind stb_reload_counter stb_reload_counter_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .term_in (term_in),
  .count   (count),
  .strobe  (strobe)
);

// File: tb/tb_stb_reload_counter.sv
module tb_stb_reload_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] term_in = 16'd0;
  logic [15:0] count;
  logic        strobe;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  stb_reload_counter dut (
    .clk(clk), .rst_n(rst_n), .en(en), .term_in(term_in),
    .count(count), .strobe(strobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // advance one edge, then settle before sampling or driving
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [15:0] t);
    rst_n = 1'b0; en = 1'b0; term_in = t;
    step(); step();
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(16'd50);
    check(count == 16'd1, "R1 count", count, 1);
    check(strobe == 1'b0, "R1 strobe", strobe, 0);
  endtask

  task automatic t_period(input logic [15:0] t);
    int n;
    int exp_p;
    exp_p = (t <= 16'd1) ? 2 : int'(t) + 1;
    do_reset(t);
    en = 1'b1;
    n = 0;
    while (!strobe && n < 70000) begin step(); n++; end
    check(int'(count) == exp_p, "R6 count at strobe", count, exp_p);
    step();
    check(count == 16'd1 && !strobe, "R5 reload after strobe", count, 1);
    n = 1;
    while (!strobe && n < 70000) begin step(); n++; end
    check(n == exp_p, "R6 period", n, exp_p);
  endtask

  task automatic t_pause();
    do_reset(16'd10);
    en = 1'b1;
    while (count != 16'd4) step();
    en = 1'b0;
    for (int i = 0; i < 5; i++) step();
    check(count == 16'd4 && !strobe, "R3 hold while disabled", count, 4);
    en = 1'b1;
    step();
    check(count == 16'd5, "R2 resume increment", count, 5);
    while (!strobe && count < 16'd20) step();
    check(count == 16'd11, "R6 strobe after pause", count, 11);
    // disable exactly at the terminal value: no strobe, no move
    do_reset(16'd3);
    en = 1'b1;
    while (count != 16'd3) step();
    en = 1'b0;
    step(); step(); step();
    check(!strobe && count == 16'd3, "R3 no strobe while paused at terminal", count, 3);
    en = 1'b1;
    step();
    check(strobe && count == 16'd4, "R4 strobe once re-enabled", strobe, 1);
    en = 1'b0;
    step();
    check(count == 16'd1 && !strobe, "R5 reload with en low", count, 1);
  endtask

  task automatic t_latency();
    do_reset(16'd100);
    en = 1'b1;
    while (count != 16'd5) step();
    term_in = 16'd3;
    step();
    check(!strobe && count == 16'd6, "R7 old terminal still used", strobe, 0);
    step();
    check(strobe == 1'b1, "R7 new terminal after one edge", strobe, 1);
  endtask

  task automatic t_reset_priority();
    do_reset(16'd1000);
    en = 1'b1;
    for (int i = 0; i < 7; i++) step();
    check(count == 16'd8, "R2 increment run", count, 8);
    rst_n = 1'b0;
    step();
    check(count == 16'd1 && !strobe, "R8 reset beats enable", count, 1);
    rst_n = 1'b1;
    step();
    check(count == 16'd2, "R8 count after reset", count, 2);
  endtask

  task automatic t_wrap();
    do_reset(16'hFFFF);
    en = 1'b1;
    while (count != 16'hFFFF) step();
    check(!strobe, "R4 no strobe before edge", strobe, 0);
    step();
    check(count == 16'h0000 && strobe, "R2 wrap to zero with strobe", count, 0);
    step();
    check(count == 16'd1 && !strobe, "R5 reload after wrap", count, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_period(16'd0);
    t_period(16'd1);
    t_period(16'd2);
    t_period(16'd7);
    t_period(16'd37);
    t_pause();
    t_latency();
    t_reset_priority();
    t_wrap();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule